// File: doc/BRIEF.md
# Serial Byte Receiver with Break Wake-Up

This block receives asynchronous serial frames on one input line. It samples the line with a tick enable that runs at sixteen times the bit rate. Each accepted byte goes into a two-entry first-in first-out store. The store reports a data-available interrupt, a framing-error flag that travels with each byte, and an overrun flag for a byte that arrived with no room left. Software-level controls are plain inputs: a module enable, a continuous-receive enable, a one-cycle arm strobe for wake-up, and a read strobe that removes the oldest byte.

When wake-up is armed, byte reception stops. A separate state machine then waits for the line to fall. That falling edge, which is the start of a break, becomes a pending receive interrupt. When the line goes high again, wake-up disarms itself and normal reception resumes. A read strobe clears the pending wake-up interrupt.

The frame state machine has four states. RX_IDLE moves to RX_START on a tick that sees the line low. RX_START goes to RX_DATA on the eighth tick if the line is still low, or back to RX_IDLE if the line is high (a false start). RX_DATA moves to RX_STOP after the eighth data bit. RX_STOP returns to RX_IDLE on the stop sample and delivers the byte. Losing the "active" condition forces any state back to RX_IDLE. The wake-up state machine has three states. WK_OFF goes to WK_ARMED on the arm strobe. WK_ARMED goes to WK_HELD on a falling edge and sets the pending interrupt. WK_HELD returns to WK_OFF on a rising edge. Dropping the module enable sends it straight to WK_OFF.

Top module: `brk_wake_uart_rx`

## Requirements
- R1: A frame is a low start bit, eight data bits sent least-significant first, and a stop bit, each 16 ticks long. The start bit is confirmed by a sample on the 8th tick after a low is first seen. Each data bit and the stop bit are then sampled every 16 ticks. A byte is stored on the stop sample.
- R2: If the line is high at the start-confirm sample, no byte is stored and the receiver returns to idle.
- R3: `rd_ferr` is 1 for a byte whose stop sample was low, and 0 otherwise. The flag is stored together with that byte.
- R4: Up to two bytes are held in arrival order. `rd_data` and `rd_ferr` show the oldest byte. A read strobe removes it.
- R5: A byte that completes while two bytes are held, with no read in the same cycle, is discarded and sets `ovr_flag`.
- R6: While `ovr_flag` is 1, no byte is received. `ovr_flag` clears in the cycle after `cont_en` is seen at 0.
- R7: `rx_irq` is 1 exactly when at least one byte is held or a wake-up event is pending.
- R8: A one-cycle `wake_arm` strobe while `rx_en` is 1 sets `wake_en`. While `wake_en` is 1, no byte is received.
- R9: While armed, a high-to-low transition of the synchronized line sets a pending wake-up interrupt. A read strobe clears it.
- R10: After the wake-up event, the next low-to-high transition clears `wake_en`, and reception of normal frames resumes.
- R11: While `rx_en` or `cont_en` is 0, no byte is received.
- R12: After reset, `rx_irq`, `ovr_flag` and `wake_en` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Enable at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high, asynchronous |
| rx_en | input | 1 | Module enable |
| cont_en | input | 1 | Continuous-receive enable; 0 clears overrun |
| wake_arm | input | 1 | One-cycle strobe that arms wake-up |
| rd_stb | input | 1 | Removes the oldest byte and clears a pending wake-up |
| rd_data | output | 8 | Oldest held byte |
| rd_ferr | output | 1 | Framing error of the oldest held byte |
| rx_irq | output | 1 | Receive interrupt |
| ovr_flag | output | 1 | Overrun |
| wake_en | output | 1 | Wake-up armed or in progress |

## Verification
The hardest states to reach are the overrun and the wake-up sequence.

Overrun needs three complete frames with no read. The third frame must finish its stop sample while both entries are occupied, and a fourth frame sent during overrun must leave no trace. The bench sends these frames back to back, then drains the store to show exactly which bytes survived.

For wake-up, the line is held low for a thirteen-bit break while armed. A behavioural model follows every clock. It checks that the pending interrupt appears with the synchronizer delay, that the break produces no byte, and that a normal frame is accepted once the line rises.

// File: rtl/uwr_pkg.sv
package uwr_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef enum logic [1:0] {
        WK_OFF,
        WK_ARMED,
        WK_HELD
    } wk_state_e;

    typedef struct packed {
        logic              ferr;
        logic [BYTE_W-1:0] data;
    } rx_word_t;

endpackage

// File: rtl/uwr_sync.sv
module uwr_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic fall,
    output logic rise
);
    logic meta_q;
    logic stab_q;
    logic prev_q;

    // Two flops bring the line into this clock domain.
    // A third flop holds the previous settled value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            stab_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= din;
            stab_q <= meta_q;
            prev_q <= stab_q;
        end
    end

    always_comb begin
        level = stab_q;
        fall  = prev_q & ~stab_q;
        rise  = ~prev_q & stab_q;
    end
endmodule

// File: rtl/uwr_frame_rx.sv
module uwr_frame_rx
    import uwr_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              active,
    input  logic              rx_s,
    output logic              done,
    output logic [BYTE_W-1:0] data,
    output logic              ferr,
    output logic              idle
);
    localparam int CNT_W = $clog2(OSR);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OSR - 1);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(BYTE_W - 1);

    rx_state_e         st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [BIT_W-1:0]  bit_q, bit_d;
    logic [BYTE_W-1:0] sh_q, sh_d;

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= RX_IDLE;
            cnt_q <= '0;
            bit_q <= '0;
            sh_q  <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            bit_q <= bit_d;
            sh_q  <= sh_d;
        end
    end

    // Next-state and output process
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        bit_d = bit_q;
        sh_d  = sh_q;
        done  = 1'b0;
        if (!active) begin
            st_d  = RX_IDLE;
            cnt_d = '0;
        end else if (tick) begin
            unique case (st_q)
                RX_IDLE: begin
                    if (!rx_s) begin
                        st_d  = RX_START;
                        cnt_d = '0;
                    end
                end
                RX_START: begin
                    if (cnt_q == MID_TICK) begin
                        cnt_d = '0;
                        bit_d = '0;
                        st_d  = rx_s ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt_q == LAST_TICK) begin
                        cnt_d = '0;
                        sh_d  = {rx_s, sh_q[BYTE_W-1:1]};
                        if (bit_q == LAST_BIT) begin
                            st_d = RX_STOP;
                        end else begin
                            bit_d = bit_q + 1'b1;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt_q == LAST_TICK) begin
                        done  = 1'b1;
                        cnt_d = '0;
                        st_d  = RX_IDLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        data = sh_q;
        ferr = ~rx_s;
        idle = (st_q == RX_IDLE);
    end
endmodule

// File: rtl/uwr_wake_fsm.sv
module uwr_wake_fsm
    import uwr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic arm,
    input  logic fall,
    input  logic rise,
    input  logic clr,
    output logic armed,
    output logic pend
);
    wk_state_e st_q, st_d;
    logic      pend_q, pend_d;

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= WK_OFF;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            pend_q <= pend_d;
        end
    end

    // Next-state process
    always_comb begin
        st_d   = st_q;
        pend_d = pend_q;
        if (clr) begin
            pend_d = 1'b0;
        end
        if (!en) begin
            st_d = WK_OFF;
        end else begin
            unique case (st_q)
                WK_OFF: begin
                    if (arm) st_d = WK_ARMED;
                end
                WK_ARMED: begin
                    if (fall) begin
                        st_d   = WK_HELD;
                        pend_d = 1'b1;
                    end
                end
                WK_HELD: begin
                    if (rise) st_d = WK_OFF;
                end
                default: st_d = WK_OFF;
            endcase
        end
    end

    // Output process
    always_comb begin
        armed = (st_q != WK_OFF);
        pend  = pend_q;
    end
endmodule

// File: rtl/uwr_rx_fifo.sv
module uwr_rx_fifo
    import uwr_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  rx_word_t                   wword,
    input  logic                       pop_req,
    input  logic                       cont_en,
    output rx_word_t                   rword,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       ovr
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    rx_word_t         mem_q [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ovr_q;
    logic             pop, accept;

    always_comb begin
        pop    = pop_req && (cnt_q != '0);
        accept = push && ((cnt_q != FULL) || pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
            ovr_q <= 1'b0;
        end else begin
            if (accept) begin
                wr_q <= (wr_q == LAST_PTR) ? '0 : wr_q + 1'b1;
            end
            if (pop) begin
                rd_q <= (rd_q == LAST_PTR) ? '0 : rd_q + 1'b1;
            end
            if (accept && !pop) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (pop && !accept) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (!cont_en) begin
                ovr_q <= 1'b0;
            end else if (push && !accept) begin
                ovr_q <= 1'b1;
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (accept && (wr_q == PTR_W'(g))) begin
                mem_q[g] <= wword;
            end
        end
    end

    always_comb begin
        rword = mem_q[rd_q];
        count = cnt_q;
        ovr   = ovr_q;
    end
endmodule

// File: rtl/brk_wake_uart_rx.sv
module brk_wake_uart_rx
    import uwr_pkg::*;
#(
    parameter int OSR        = 16,
    parameter int FIFO_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rxd,
    input  logic              rx_en,
    input  logic              cont_en,
    input  logic              wake_arm,
    input  logic              rd_stb,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_ferr,
    output logic              rx_irq,
    output logic              ovr_flag,
    output logic              wake_en
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic              rx_s, fall_s, rise_s;
    logic              byte_done, byte_ferr, rx_idle, active;
    logic [BYTE_W-1:0] byte_data;
    logic              wake_pend, armed;
    logic [CNT_W-1:0]  fcnt;
    logic              ovr_i;
    rx_word_t          in_word, head_word;

    uwr_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .level (rx_s),
        .fall  (fall_s),
        .rise  (rise_s)
    );

    always_comb begin
        active  = rx_en && cont_en && !armed && !ovr_i;
        in_word = '{ferr: byte_ferr, data: byte_data};
    end

    uwr_frame_rx #(.OSR(OSR)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick16),
        .active (active),
        .rx_s   (rx_s),
        .done   (byte_done),
        .data   (byte_data),
        .ferr   (byte_ferr),
        .idle   (rx_idle)
    );

    uwr_wake_fsm u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (rx_en),
        .arm   (wake_arm),
        .fall  (fall_s),
        .rise  (rise_s),
        .clr   (rd_stb),
        .armed (armed),
        .pend  (wake_pend)
    );

    uwr_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (byte_done),
        .wword   (in_word),
        .pop_req (rd_stb),
        .cont_en (cont_en),
        .rword   (head_word),
        .count   (fcnt),
        .ovr     (ovr_i)
    );

    always_comb begin
        rd_data  = head_word.data;
        rd_ferr  = head_word.ferr;
        rx_irq   = (fcnt != '0) || wake_pend;
        ovr_flag = ovr_i;
        wake_en  = armed;
    end
endmodule

// File: rtl/uwr_chk.sv
module uwr_chk #(
    parameter int DEPTH = 2,
    parameter int CW    = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_en,
    input logic          cont_en,
    input logic          ovr,
    input logic          wake_en,
    input logic          wake_pend,
    input logic          rx_s,
    input logic          rx_idle,
    input logic [CW-1:0] fcnt
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    // R4
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fcnt <= FULL);

    // R5
    ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> ($past(fcnt) == FULL));

    // R6
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cont_en |=> !ovr);

    // R8
    wake_blocks_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_en |=> rx_idle);

    // R9
    pend_while_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_pend) |-> wake_en);

    // R10
    wake_drop_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wake_en) && $past(rx_en)) |-> $past(rx_s));
endmodule

bind brk_wake_uart_rx uwr_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .cont_en   (cont_en),
    .ovr       (ovr_flag),
    .wake_en   (wake_en),
    .wake_pend (wake_pend),
    .rx_s      (rx_s),
    .rx_idle   (rx_idle),
    .fcnt      (fcnt)
);

// File: tb/sim_brk_wake_uart_rx.sv
module sim_brk_wake_uart_rx;
    localparam int TDIV  = 4;
    localparam int DEPTH = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b0;
    logic       cont_en = 1'b0;
    logic       wake_arm = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       rd_ferr, rx_irq, ovr_flag, wake_en;

    int n_chk = 0;
    int n_bad = 0;
    int tdiv = 0;

    always #5 clk = ~clk;

    brk_wake_uart_rx #(.OSR(16), .FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .rx_en(rx_en), .cont_en(cont_en), .wake_arm(wake_arm), .rd_stb(rd_stb),
        .rd_data(rd_data), .rd_ferr(rd_ferr), .rx_irq(rx_irq),
        .ovr_flag(ovr_flag), .wake_en(wake_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Tick generator: one tick every TDIV clocks
    always @(negedge clk) begin
        if (!rst_n) begin
            tdiv = 0;
            tick16 = 1'b0;
        end else begin
            tick16 = (tdiv == 0);
            tdiv = (tdiv + 1) % TDIV;
        end
    end

    // Behavioural reference model
    int         m_s1, m_s2, m_prev, m_tk, m_wst;
    bit         m_ovr, m_pend;
    logic [7:0] m_acc;
    logic [8:0] m_q[$];

    always @(posedge clk) begin
        int  s2o, n;
        bit  fall, rise, act, done, dferr;
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_prev = 1; m_tk = -1; m_wst = 0;
            m_ovr = 0; m_pend = 0; m_acc = '0; m_q.delete();
        end else begin
            s2o   = m_s2;
            fall  = (m_prev == 1) && (s2o == 0);
            rise  = (m_prev == 0) && (s2o == 1);
            act   = rx_en && cont_en && (m_wst == 0) && !m_ovr;
            done  = 0;
            dferr = 0;
            if (!act) begin
                m_tk = -1;
            end else if (tick16) begin
                if (m_tk < 0) begin
                    if (s2o == 0) m_tk = 0;
                end else begin
                    m_tk++;
                    if (m_tk == 8) begin
                        if (s2o == 1) m_tk = -1;
                    end else if (m_tk > 8 && ((m_tk - 8) % 16) == 0) begin
                        n = (m_tk - 8) / 16;
                        if (n <= 8) begin
                            m_acc[n-1] = s2o[0];
                        end else begin
                            done  = 1;
                            dferr = (s2o == 0);
                            m_tk  = -1;
                        end
                    end
                end
            end
            if (rd_stb && m_q.size() > 0) void'(m_q.pop_front());
            if (done) begin
                if (m_q.size() < DEPTH) m_q.push_back({dferr, m_acc});
                else m_ovr = 1;
            end
            if (!cont_en) m_ovr = 0;
            if (rd_stb) m_pend = 0;
            if (!rx_en) m_wst = 0;
            else case (m_wst)
                0: if (wake_arm) m_wst = 1;
                1: if (fall) begin m_wst = 2; m_pend = 1; end
                default: if (rise) m_wst = 0;
            endcase
            m_prev = s2o;
            m_s2   = m_s1;
            m_s1   = rxd;
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R7 irq vs model", rx_irq, (m_q.size() > 0) || m_pend);
            chk("R5 ovr vs model", ovr_flag, m_ovr);
            chk("R8 wake_en vs model", wake_en, m_wst != 0);
            if (m_q.size() > 0) chk("R4 head vs model", {rd_ferr, rd_data}, m_q[0]);
        end
    end

    task automatic line(input logic v, input int nt);
        rxd = v;
        repeat (nt * TDIV) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input logic stopv);
        line(1'b0, 16);
        for (int i = 0; i < 8; i++) line(b[i], 16);
        line(stopv, 16);
        line(1'b1, 16);
    endtask

    task automatic rd();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 irq after reset", rx_irq, 0);
        chk("R12 ovr after reset", ovr_flag, 0);
        chk("R12 wake after reset", wake_en, 0);
        rx_en = 1'b1;
        cont_en = 1'b1;
        line(1'b1, 8);

        // R1 plain byte
        send(8'hA5, 1'b1);
        chk("R1 data A5", rd_data, 8'hA5);
        chk("R3 ferr clear", rd_ferr, 0);
        chk("R7 irq with byte", rx_irq, 1);
        rd();
        chk("R7 irq empty", rx_irq, 0);

        // R3 low stop bit
        send(8'h3C, 1'b0);
        chk("R3 data 3C", rd_data, 8'h3C);
        chk("R3 ferr set", rd_ferr, 1);
        rd();

        // R2 false start
        line(1'b0, 3);
        line(1'b1, 40);
        chk("R2 no byte", rx_irq, 0);

        // R5 and R4: three bytes without a read
        send(8'h11, 1'b1);
        send(8'h22, 1'b1);
        send(8'h33, 1'b1);
        chk("R5 ovr set", ovr_flag, 1);
        chk("R4 head 11", rd_data, 8'h11);
        // R6 byte during overrun is ignored
        send(8'h44, 1'b1);
        rd();
        chk("R4 head 22", rd_data, 8'h22);
        rd();
        chk("R6 nothing after overrun", rx_irq, 0);
        chk("R6 ovr still set", ovr_flag, 1);
        cont_en = 1'b0;
        @(negedge clk);
        cont_en = 1'b1;
        @(negedge clk);
        chk("R6 ovr cleared", ovr_flag, 0);
        send(8'hC3, 1'b1);
        chk("R6 rx after clear", rd_data, 8'hC3);
        rd();

        // R8 R9 R10 wake-up on break
        wake_arm = 1'b1;
        @(negedge clk);
        wake_arm = 1'b0;
        @(negedge clk);
        chk("R8 wake armed", wake_en, 1);
        chk("R8 no irq yet", rx_irq, 0);
        line(1'b0, 13 * 16);
        chk("R9 irq on break", rx_irq, 1);
        chk("R9 still armed", wake_en, 1);
        line(1'b1, 4);
        chk("R10 wake self-clear", wake_en, 0);
        rd();
        chk("R9 read clears irq", rx_irq, 0);
        send(8'h5A, 1'b1);
        chk("R10 rx resumed", rd_data, 8'h5A);
        rd();

        // R11 enables gate reception
        cont_en = 1'b0;
        send(8'h77, 1'b1);
        chk("R11 cont_en low", rx_irq, 0);
        cont_en = 1'b1;
        rx_en = 1'b0;
        send(8'h78, 1'b1);
        chk("R11 rx_en low", rx_irq, 0);
        rx_en = 1'b1;
        line(1'b1, 4);
        send(8'h79, 1'b1);
        chk("R11 re-enabled", rd_data, 8'h79);
        rd();

        line(1'b1, 8);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule